// File: doc/BRIEF.md
# ADC Auto-Trigger Source Selector

This block decides when an analog-to-digital converter begins a conversion without a software start. A 3-bit select field picks one of eight event flags: seven come from peripherals and one is the converter's own conversion-complete flag. A rising edge of the picked flag becomes a one-cycle start pulse. The pulse is gated by an auto-trigger enable bit, a converter enable bit and a busy input from the converter.

Edge detection sits after the source multiplexer. Moving the select from a source whose flag is low to a source whose flag is high therefore counts as a positive edge and fires a start. The one exception is a move into free-running mode (select 000), which never fires. In free-running mode each completed conversion starts the next one. The very first conversion still needs a start from elsewhere.

Software reaches two small registers through a write port and a registered read port. Address 0 is control: bit 0 is the converter enable and bit 1 is the auto-trigger enable. Address 1 holds the select field in bits 2:0.

Top module: `adc_trig_sel`

## Requirements
- R1: The select value picks the trigger flag: 000 uses `conv_done`, and a value k from 1 to 7 uses `evt_flags[k]`. The sources in order 1 to 7 are: analog comparator, external interrupt 0, timer0 compare A, timer0 overflow, timer1 compare B, timer1 overflow, timer1 capture. Edges on unselected flags have no effect.
- R2: While the auto-trigger enable (control bit 1) is 0, `conv_start` stays low whatever the flags and the select do.
- R3: A start is requested only on a 0-to-1 transition of the selected flag. A flag held high gives no further start.
- R4: Changing the select from a source whose flag is low to a source whose flag is high produces a start.
- R5: While the converter enable (control bit 0) is 0, no start is produced.
- R6: Writing select 000 while the select is nonzero never produces a start, even when `conv_done` is already high.
- R7: In free-running mode a rising edge of `conv_done` produces a start.
- R8: A trigger edge that arrives while `conv_busy` is high is dropped and is not replayed later.
- R9: `conv_start` is a single-cycle pulse. It is high in the cycle after the clock edge at which the selected flag is first seen high.
- R10: Register bits other than control bits 1:0 and select bits 2:0 read as zero and ignore writes.
- R11: Synchronous reset clears the select field, both enable bits, the edge history, `conv_start` and `reg_rdata`.
- R12: `reg_rdata` shows the register at `reg_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_flags | input | 7 | Peripheral event flag levels, bit k is source k (1..7) |
| conv_done | input | 1 | Conversion-complete flag level, source 0 |
| conv_busy | input | 1 | Converter busy; start requests are dropped while high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 control, 1 select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered readback of the addressed register |
| conv_start | output | 1 | One-cycle conversion start pulse |

## Verification
The bench builds the block with its default values: a 3-bit select, 8-bit register data and a 1-bit address. This gives all eight sources and the full select encoding. It also leaves five reserved bits above the select field and six above the control field to probe with writes of ones. Directed sequences cover source switches from low to high flags, entry into free-running mode with `conv_done` already high, busy dropping, and each enable held off. A long randomized run of flags, busy and register writes is then compared cycle by cycle against a behavioural model.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int unsigned TRIG_SEL_W = 3;

  typedef enum logic [TRIG_SEL_W-1:0] {
    SRC_FREE_RUN = 3'd0,
    SRC_ACOMP    = 3'd1,
    SRC_EXT_IRQ0 = 3'd2,
    SRC_T0_CMPA  = 3'd3,
    SRC_T0_OVF   = 3'd4,
    SRC_T1_CMPB  = 3'd5,
    SRC_T1_OVF   = 3'd6,
    SRC_T1_CAPT  = 3'd7
  } trig_src_e;

  localparam int unsigned REG_CTRL_ADDR = 0;
  localparam int unsigned REG_SEL_ADDR  = 1;
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_AUTO_BIT = 1;
endpackage

// File: rtl/adc_trig_regs.sv
module adc_trig_regs #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              conv_en,
  output logic              auto_en,
  output logic [SEL_W-1:0]  sel,
  output logic [SEL_W-1:0]  sel_next,
  output logic              fr_entry,
  output logic [DATA_W-1:0] rdata
);
  import adc_trig_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(REG_SEL_ADDR);

  logic             wr_ctrl, wr_sel;
  logic [DATA_W-1:0] rd_mux;
  logic             unused_wbits;

  assign wr_ctrl      = wr_en && (addr == A_CTRL);
  assign wr_sel       = wr_en && (addr == A_SEL);
  assign unused_wbits = ^wdata[DATA_W-1:SEL_W];

  assign sel_next = wr_sel ? wdata[SEL_W-1:0] : sel;
  assign fr_entry = wr_sel && (wdata[SEL_W-1:0] == '0) && (sel != '0);

  always_comb begin
    rd_mux = '0;
    if (addr == A_CTRL) begin
      rd_mux[CTRL_EN_BIT]   = conv_en;
      rd_mux[CTRL_AUTO_BIT] = auto_en;
    end else if (addr == A_SEL) begin
      rd_mux[SEL_W-1:0] = sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_en <= 1'b0;
      auto_en <= 1'b0;
      sel     <= '0;
      rdata   <= '0;
    end else begin
      rdata <= rd_mux;
      if (wr_ctrl) begin
        conv_en <= wdata[CTRL_EN_BIT];
        auto_en <= wdata[CTRL_AUTO_BIT];
      end
      if (wr_sel) sel <= wdata[SEL_W-1:0];
    end
  end

  // R10: the select register takes only its field from a write
  a_r10_sel_field_only: assert property (@(posedge clk) disable iff (rst)
    wr_sel |=> (sel == $past(wdata[SEL_W-1:0])));

  // R12: readback of the control register follows one cycle later
  a_r12_ctrl_readback: assert property (@(posedge clk) disable iff (rst)
    (addr == A_CTRL && !wr_en) |=> (rdata[CTRL_EN_BIT] == conv_en));
endmodule

// File: rtl/adc_trig_src_mux.sv
module adc_trig_src_mux #(
  parameter int unsigned SEL_W = 3
) (
  input  logic                    conv_done,
  input  logic [(1<<SEL_W)-1:1]   evt_flags,
  input  logic [SEL_W-1:0]        sel,
  input  logic [SEL_W-1:0]        sel_next,
  output logic                    flag_cur,
  output logic                    flag_next
);
  localparam int unsigned NUM_SRC = 1 << SEL_W;

  logic [NUM_SRC-1:0] src_vec;

  assign src_vec[0] = conv_done;
  for (genvar gi = 1; gi < NUM_SRC; gi++) begin : g_src
    assign src_vec[gi] = evt_flags[gi];
  end

  assign flag_cur  = src_vec[sel];
  assign flag_next = src_vec[sel_next];
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge (
  input  logic clk,
  input  logic rst,
  input  logic flag_cur,
  input  logic flag_next,
  input  logic fr_entry,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst)           prev_q <= 1'b0;
    else if (fr_entry) prev_q <= flag_next;
    else               prev_q <= flag_cur;
  end

  assign rise = flag_cur && !prev_q;

  // R6: entering free-running mode with an unchanged flag never gives an edge
  a_r6_fr_entry_quiet: assert property (@(posedge clk) disable iff (rst)
    ($past(fr_entry) && (flag_cur == $past(flag_next))) |-> !rise);

  // R3: a flag seen high on two edges in a row without a mode entry has no edge
  a_r3_level_no_edge: assert property (@(posedge clk) disable iff (rst)
    (flag_cur && $past(flag_cur) && !$past(fr_entry) && $stable(flag_cur)) |-> !rise);
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [(1<<SEL_W)-1:1] evt_flags,
  input  logic                  conv_done,
  input  logic                  conv_busy,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  conv_start
);
  logic             conv_en, auto_en, fr_entry;
  logic [SEL_W-1:0] sel, sel_next;
  logic             flag_cur, flag_next, rise;

  adc_trig_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .conv_en(conv_en), .auto_en(auto_en), .sel(sel), .sel_next(sel_next),
    .fr_entry(fr_entry), .rdata(reg_rdata)
  );

  adc_trig_src_mux #(.SEL_W(SEL_W)) u_mux (
    .conv_done(conv_done), .evt_flags(evt_flags), .sel(sel), .sel_next(sel_next),
    .flag_cur(flag_cur), .flag_next(flag_next)
  );

  adc_trig_edge u_edge (
    .clk(clk), .rst(rst), .flag_cur(flag_cur), .flag_next(flag_next),
    .fr_entry(fr_entry), .rise(rise)
  );

  always_ff @(posedge clk) begin
    if (rst) conv_start <= 1'b0;
    else     conv_start <= auto_en && conv_en && !conv_busy && rise;
  end

  // R2: no automatic start with auto-trigger disabled
  a_r2_auto_gate: assert property (@(posedge clk) disable iff (rst)
    !auto_en |=> !conv_start);

  // R5: no start with the converter disabled
  a_r5_enable_gate: assert property (@(posedge clk) disable iff (rst)
    !conv_en |=> !conv_start);

  // R8: busy drops the request
  a_r8_busy_drop: assert property (@(posedge clk) disable iff (rst)
    conv_busy |=> !conv_start);

  // R9: a start is always preceded by an edge seen by the detector
  a_r9_start_from_edge: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $past(rise));
endmodule

// File: tb/adc_trig_sel_tb.sv
module adc_trig_sel_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:1] evt_flags;
  logic       conv_done, conv_busy, reg_wr;
  logic [0:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       conv_start;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_trig_sel u_dut (
    .clk(clk), .rst(rst), .evt_flags(evt_flags), .conv_done(conv_done),
    .conv_busy(conv_busy), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_start(conv_start)
  );

  // behavioural reference model
  int  m_sel = 0;
  bit  m_en = 0, m_auto = 0, m_prev = 0;
  bit  exp_start = 0;
  int  exp_rdata = 0;

  always @(posedge clk) begin
    bit cur;
    if (rst) begin
      m_sel = 0; m_en = 0; m_auto = 0; m_prev = 0;
      exp_start = 0; exp_rdata = 0;
    end else begin
      cur = (m_sel == 0) ? conv_done : evt_flags[m_sel];
      exp_start = m_auto && m_en && !conv_busy && cur && !m_prev;
      exp_rdata = (reg_addr == 1) ? m_sel : (int'(m_auto) * 2 + int'(m_en));
      if (reg_wr && reg_addr == 1 && reg_wdata[2:0] == 0 && m_sel != 0) m_prev = conv_done;
      else m_prev = cur;
      if (reg_wr && reg_addr == 0) begin m_en = reg_wdata[0]; m_auto = reg_wdata[1]; end
      if (reg_wr && reg_addr == 1) m_sel = reg_wdata[2:0];
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (conv_start !== exp_start) begin
        n_errors++;
        $display("FAIL R9 model start: actual=%0b expected=%0b t=%0t", conv_start, exp_start, $time);
      end
      n_checks++;
      if (reg_rdata !== 8'(exp_rdata)) begin
        n_errors++;
        $display("FAIL R12 model rdata: actual=%0h expected=%0h t=%0t", reg_rdata, exp_rdata, $time);
      end
    end
  end

  task automatic chk(input logic act, input logic expv, input string tag);
    n_checks++;
    if (act !== expv) begin
      n_errors++;
      $display("FAIL %s: actual=%0b expected=%0b t=%0t", tag, act, expv, $time);
    end
  endtask

  task automatic chk8(input logic [7:0] act, input logic [7:0] expv, input string tag);
    n_checks++;
    if (act !== expv) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h t=%0t", tag, act, expv, $time);
    end
  endtask

  // advance to just after the next falling edge: outputs are then settled
  task automatic cyc();
    @(negedge clk); #2;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 0; reg_wdata = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1; evt_flags = 0; conv_done = 0; conv_busy = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) cyc();
    chk(conv_start, 1'b0, "R11 start in reset");
    chk8(reg_rdata, 8'h00, "R11 rdata in reset");
    rst = 0;
    cyc();
    reg_addr = 1; cyc(); cyc();
    chk8(reg_rdata, 8'h00, "R11 select cleared");

    // R10: reserved bits ignore ones
    wr(0, 8'hFF);
    wr(1, 8'hFD);
    reg_addr = 1; cyc(); cyc();
    chk8(reg_rdata, 8'h05, "R10 select readback");
    reg_addr = 0; cyc();
    chk8(reg_rdata, 8'h03, "R12 control readback");

    // R1: unselected source ignored, selected source fires
    evt_flags[3] = 1; cyc(); cyc();
    chk(conv_start, 1'b0, "R1 unselected flag");
    evt_flags[5] = 1; cyc();
    chk(conv_start, 1'b1, "R1 selected flag fires");
    cyc();
    chk(conv_start, 1'b0, "R9 single pulse");
    cyc(); cyc();
    chk(conv_start, 1'b0, "R3 held level");

    // R4: switch from low source to high source
    evt_flags[5] = 0; cyc();
    wr(1, 8'h03);
    chk(conv_start, 1'b0, "R4 write cycle");
    cyc();
    chk(conv_start, 1'b1, "R4 switch fires");

    // R6: switch into free-running with conv_done high, old flag low
    evt_flags[3] = 0; conv_done = 1; cyc(); cyc();
    wr(1, 8'h00);
    chk(conv_start, 1'b0, "R6 write cycle");
    cyc(); chk(conv_start, 1'b0, "R6 no fire");
    cyc(); chk(conv_start, 1'b0, "R6 still quiet");

    // R7: free-running conv_done edge
    conv_done = 0; cyc();
    conv_done = 1; cyc();
    chk(conv_start, 1'b1, "R7 completion restarts");

    // R8: busy drops the edge, no replay
    conv_done = 0; cyc();
    conv_busy = 1; conv_done = 1; cyc();
    chk(conv_start, 1'b0, "R8 dropped while busy");
    conv_busy = 0; cyc(); cyc();
    chk(conv_start, 1'b0, "R8 not queued");

    // R5: converter disabled
    conv_done = 0;
    wr(0, 8'h02); cyc();
    conv_done = 1; cyc();
    chk(conv_start, 1'b0, "R5 converter off");

    // R2: auto-trigger off
    wr(0, 8'h01);
    wr(1, 8'h07);
    evt_flags[7] = 0; cyc();
    evt_flags[7] = 1; cyc();
    chk(conv_start, 1'b0, "R2 auto off");

    // randomized phase, model compared every cycle
    wr(0, 8'h03);
    for (int i = 0; i < 3000; i++) begin
      evt_flags = 7'($urandom);
      conv_done = 1'($urandom);
      conv_busy = ($urandom % 4) == 0;
      reg_addr  = 1'($urandom);
      reg_wr    = ($urandom % 6) == 0;
      reg_wdata = 8'($urandom);
      if (reg_wr && reg_addr == 0 && ($urandom % 3) != 0) reg_wdata[1:0] = 2'b11;
      cyc();
    end
    reg_wr = 0;
    cyc(); cyc();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule